// File: doc/BRIEF.md
# H-Bridge Gate Control with Dead Time

This block is the digital core of a full H-bridge gate driver with two legs, A and B. Each leg has a low-side and a high-side command. From these commands, a disable input and synchronous undervoltage flags, the block produces four gate enables. Every gate enable turns off at once. Every turn-on waits for a run-time dead time, counted in clock cycles. A low-side command always wins over the high-side command of the same leg. Because of this, holding a leg's high command at 1 gives single-input operation: the low command alone then selects which switch of that leg conducts.

Releasing the disable starts a bootstrap refresh. Both low-side gates conduct for a programmed number of cycles, and the bridge then follows its commands. The dead time for any high-side turn-on starts only after the refresh ends. Reset leaves the block in the disabled state, so the first release also runs a refresh.

The command inputs and the disable input each pass through a two-flop synchronizer. The undervoltage flags arrive already synchronous and act on the outputs in the same cycle.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: When a leg's synchronized low command is 1, that leg's high gate is 0, whatever its high command is. A high gate that is on falls 2 cycles after its leg's low command rises.
- R2: While the synchronized disable is 1, all four gates are 0, whatever the other inputs are. A rise of the disable input clears gates that are on 2 cycles later.
- R3: While `uvMain` is 1, all four gates are 0 in the same cycle. When `uvMain` returns to 0, a gate that is still requested turns on `max(deadCycles,1)` cycles later.
- R4: `uvBootA` (or `uvBootB`) forces only that leg's high gate to 0 in the same cycle. The low gate of that leg keeps following its low command with the normal timing.
- R5: A gate turns on `max(deadCycles,1)+2` cycles after its command asks for it: 2 cycles of synchronizer, then the dead time.
- R6: A gate turns off 2 cycles after its command stops asking for it. No dead time is added to a turn-off.
- R7: The low gate and the high gate of one leg are never 1 in the same cycle.
- R8: With a leg's high command held at 1, a fall of the low command turns the low gate off after 2 cycles and the high gate on after `max(deadCycles,1)+2` cycles. A rise of the low command does the reverse.
- R9: When the disable input falls, both low gates rise 3 cycles later. They stay on for `max(refreshCycles,1)` cycles, and both high gates are 0 for that whole time.
- R10: After a disable release, a high gate that is requested rises `3+max(refreshCycles,1)+max(deadCycles,1)` cycles after the release.
- R11: A command pulse whose synchronized width is shorter than the dead time produces no output pulse.
- R12: A low gate whose command is 1 throughout the refresh stays on without a gap from the start of the refresh into normal operation.
- R13: During reset all gates are 0. Reset counts as disabled, so the first release of the disable input runs a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdLowA | input | 1 | Leg A low-side command (asynchronous) |
| cmdHighA | input | 1 | Leg A high-side command (asynchronous) |
| cmdLowB | input | 1 | Leg B low-side command (asynchronous) |
| cmdHighB | input | 1 | Leg B high-side command (asynchronous) |
| disableIn | input | 1 | Bridge disable, active high (asynchronous) |
| uvMain | input | 1 | Common-supply undervoltage flag (synchronous) |
| uvBootA | input | 1 | Leg A high-side supply undervoltage flag (synchronous) |
| uvBootB | input | 1 | Leg B high-side supply undervoltage flag (synchronous) |
| deadCycles | input | DT_W | Turn-on delay in cycles; 0 acts as 1 |
| refreshCycles | input | RF_W | Refresh pulse width in cycles; 0 acts as 1 |
| gateLowA | output | 1 | Leg A low-side gate enable |
| gateHighA | output | 1 | Leg A high-side gate enable |
| gateLowB | output | 1 | Leg B low-side gate enable |
| gateHighB | output | 1 | Leg B high-side gate enable |

## Verification
The hardest case to reach is the moment the refresh ends. Three things meet there: the forced low-side pulse stops, a low gate that is still commanded must not glitch, and a high-side dead time starts counting from zero. The stimulus gets there by setting the commands while the bridge is disabled, then releasing the disable and recording the first rise and fall cycle of every gate. One leg is in single-input mode with a high request. The other leg holds its low command at 1 through the refresh. A monitor that runs for the whole test checks both legs for overlap of their two gates.

// File: rtl/hbg_pkg.sv
`timescale 1ns/1ps
package hbg_pkg;
  localparam int NUM_LEGS  = 2;
  localparam int NUM_GATES = 2 * NUM_LEGS;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_REFRESH = 2'd1,
    ST_RUN     = 2'd2
  } bridgeState_e;

  // Strobes from control to the gate timing datapath.
  typedef struct packed {
    logic [NUM_LEGS-1:0] reqLow;   // low gate requested
    logic [NUM_LEGS-1:0] reqHigh;  // high gate requested
    logic                forceLow; // refresh: low gates on now
    logic                primeLow; // refresh: mark low counters settled
  } gateStrobes_t;
endpackage

// File: rtl/hbg_sync.sv
`timescale 1ns/1ps
module hbg_sync #(
  parameter int   WIDTH     = 1,
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= {WIDTH{RESET_VAL}};
    else       chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= {WIDTH{RESET_VAL}};
      else       chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/hbg_ctrl.sv
`timescale 1ns/1ps
module hbg_ctrl
  import hbg_pkg::*;
#(
  parameter int RF_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_LEGS-1:0] cmdLow,
  input  logic [NUM_LEGS-1:0] cmdHigh,
  input  logic [NUM_LEGS-1:0] uvBoot,
  input  logic                disSync,
  input  logic                uvMain,
  input  logic [RF_W-1:0]     refreshCycles,
  output gateStrobes_t        strobes
);
  bridgeState_e state;
  logic [RF_W-1:0] refCnt;
  logic [RF_W-1:0] refEff;

  assign refEff = (refreshCycles == '0) ? RF_W'(1) : refreshCycles;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_OFF;
      refCnt <= '0;
    end else begin
      unique case (state)
        ST_OFF: begin
          if (!disSync) begin
            state  <= ST_REFRESH;
            refCnt <= RF_W'(1);
          end
        end
        ST_REFRESH: begin
          if (disSync)                state  <= ST_OFF;
          else if (refCnt >= refEff)  state  <= ST_RUN;
          else                        refCnt <= refCnt + RF_W'(1);
        end
        ST_RUN: begin
          if (disSync) state <= ST_OFF;
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  // Low command wins over high on each leg; the flags mask the requests.
  always_comb begin
    strobes = '0;
    if (!disSync && !uvMain) begin
      unique case (state)
        ST_REFRESH: begin
          strobes.reqLow   = '1;
          strobes.forceLow = 1'b1;
          strobes.primeLow = 1'b1;
        end
        ST_RUN: begin
          strobes.reqLow  = cmdLow;
          strobes.reqHigh = cmdHigh & ~cmdLow & ~uvBoot;
        end
        default: ;
      endcase
    end
  end

  // R9: a refresh is entered only from the disabled state
  assert_refresh_entry_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REFRESH && $past(state) != ST_REFRESH) |-> $past(state) == ST_OFF);

  // R9: the refresh never runs past its programmed width
  assert_refresh_width_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REFRESH) |-> (refCnt <= refEff));

  // R10: normal operation starts only after a refresh that ran its full width
  assert_run_after_refresh_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && $past(state) == ST_REFRESH) |-> ($past(refCnt) >= $past(refEff)));
endmodule

// File: rtl/hbg_datapath.sv
`timescale 1ns/1ps
module hbg_datapath
  import hbg_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gateStrobes_t         strobes,
  input  logic [DT_W-1:0]      deadCycles,
  output logic [NUM_GATES-1:0] gateOn
);
  localparam logic [DT_W-1:0] CNT_MAX = {DT_W{1'b1}};

  logic [DT_W-1:0] deadEff;
  assign deadEff = (deadCycles == '0) ? DT_W'(1) : deadCycles;

  logic [NUM_GATES-1:0] gateReq;

  // Even gate index = low side of a leg, odd index = high side.
  for (genvar g = 0; g < NUM_GATES; g++) begin : gGate
    localparam int  LEG    = g / 2;
    localparam bit  IS_LOW = (g % 2) == 0;

    logic            prime;
    logic            force_;
    logic [DT_W-1:0] onCnt;

    if (IS_LOW) begin : gLow
      assign gateReq[g] = strobes.reqLow[LEG];
      assign prime      = strobes.primeLow;
      assign force_     = strobes.forceLow;
    end else begin : gHigh
      assign gateReq[g] = strobes.reqHigh[LEG];
      assign prime      = 1'b0;
      assign force_     = 1'b0;
    end

    // Counts cycles the request has been held; cleared as soon as it drops.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                onCnt <= '0;
      else if (!gateReq[g])     onCnt <= '0;
      else if (prime)           onCnt <= CNT_MAX;
      else if (onCnt != CNT_MAX) onCnt <= onCnt + DT_W'(1);
    end

    assign gateOn[g] = force_ | (gateReq[g] & (onCnt >= deadEff));

    // R5: outside a refresh, a gate rises only after a request held a cycle
    assert_delayed_on_R5: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(gateOn[g]) && !force_) |-> $past(gateReq[g]));

    // R6: a gate whose request is gone is off in the same cycle
    assert_prompt_off_R6: assert property (@(posedge clk) disable iff (!rstN)
      (!gateReq[g] && !force_) |-> !gateOn[g]);
  end

  for (genvar l = 0; l < NUM_LEGS; l++) begin : gLegCheck
    // R7: the two gates of a leg never conduct together
    assert_no_shoot_R7: assert property (@(posedge clk) disable iff (!rstN)
      !(gateOn[2*l] && gateOn[2*l+1]));
  end
endmodule

// File: rtl/hbridge_gate_ctrl.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int DT_W        = 8,
  parameter int RF_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdLowA,
  input  logic            cmdHighA,
  input  logic            cmdLowB,
  input  logic            cmdHighB,
  input  logic            disableIn,
  input  logic            uvMain,
  input  logic            uvBootA,
  input  logic            uvBootB,
  input  logic [DT_W-1:0] deadCycles,
  input  logic [RF_W-1:0] refreshCycles,
  output logic            gateLowA,
  output logic            gateHighA,
  output logic            gateLowB,
  output logic            gateHighB
);
  logic [NUM_GATES-1:0] cmdRaw;
  logic [NUM_GATES-1:0] cmdSync;
  logic                 disSync;
  logic [NUM_LEGS-1:0]  cmdLowS;
  logic [NUM_LEGS-1:0]  cmdHighS;
  logic [NUM_LEGS-1:0]  uvBoot;
  logic [NUM_GATES-1:0] gateOn;
  gateStrobes_t         strobes;

  assign cmdRaw = {cmdHighB, cmdLowB, cmdHighA, cmdLowA};
  assign uvBoot = {uvBootB, uvBootA};

  hbg_sync #(.WIDTH(NUM_GATES), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) uCmdSync (
    .clk(clk), .rstN(rstN), .din(cmdRaw), .dout(cmdSync));

  hbg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) uDisSync (
    .clk(clk), .rstN(rstN), .din(disableIn), .dout(disSync));

  for (genvar l = 0; l < NUM_LEGS; l++) begin : gSplit
    assign cmdLowS[l]  = cmdSync[2*l];
    assign cmdHighS[l] = cmdSync[2*l+1];
  end

  hbg_ctrl #(.RF_W(RF_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdLow(cmdLowS), .cmdHigh(cmdHighS),
    .uvBoot(uvBoot), .disSync(disSync), .uvMain(uvMain),
    .refreshCycles(refreshCycles), .strobes(strobes));

  hbg_datapath #(.DT_W(DT_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .deadCycles(deadCycles),
    .gateOn(gateOn));

  assign gateLowA  = gateOn[0];
  assign gateHighA = gateOn[1];
  assign gateLowB  = gateOn[2];
  assign gateHighB = gateOn[3];

  // R2: a synchronized disable holds every gate low
  assert_disable_all_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    disSync |-> (gateOn == '0));

  // R3: common-supply undervoltage holds every gate low
  assert_uv_main_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    uvMain |-> (gateOn == '0));

  // R4: a high-side supply flag clears only its own high gate
  assert_boot_a_R4: assert property (@(posedge clk) disable iff (!rstN)
    uvBootA |-> !gateHighA);
  assert_boot_b_R4: assert property (@(posedge clk) disable iff (!rstN)
    uvBootB |-> !gateHighB);

  // R1: a synchronized low command keeps the same leg's high gate off
  assert_low_wins_a_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmdLowS[0] |-> !gateHighA);
  assert_low_wins_b_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmdLowS[1] |-> !gateHighB);
endmodule

// File: tb/hbridge_gate_ctrl_test.sv
`timescale 1ns/1ps
module hbridge_gate_ctrl_test;
  localparam int DT_W = 8;
  localparam int RF_W = 8;
  localparam int DEAD = 4;
  localparam int REFW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdLowA = 0, cmdHighA = 0, cmdLowB = 0, cmdHighB = 0;
  logic disableIn = 1'b1;
  logic uvMain = 0, uvBootA = 0, uvBootB = 0;
  logic [DT_W-1:0] deadCycles = DT_W'(DEAD);
  logic [RF_W-1:0] refreshCycles = RF_W'(REFW);
  logic gateLowA, gateHighA, gateLowB, gateHighB;

  int checks = 0;
  int fails = 0;
  int shootErrs = 0;
  bit done = 0;
  int riseAt [4];
  int fallAt [4];

  wire [3:0] outs = {gateHighB, gateLowB, gateHighA, gateLowA};

  always #2.5 clk = ~clk;

  hbridge_gate_ctrl #(.DT_W(DT_W), .RF_W(RF_W)) uut (
    .clk(clk), .rstN(rstN),
    .cmdLowA(cmdLowA), .cmdHighA(cmdHighA), .cmdLowB(cmdLowB), .cmdHighB(cmdHighB),
    .disableIn(disableIn), .uvMain(uvMain), .uvBootA(uvBootA), .uvBootB(uvBootB),
    .deadCycles(deadCycles), .refreshCycles(refreshCycles),
    .gateLowA(gateLowA), .gateHighA(gateHighA), .gateLowB(gateLowB), .gateHighB(gateHighB));

  // R7 monitor: sampled away from the active edge
  always @(negedge clk) begin
    if (rstN && ((gateLowA && gateHighA) || (gateLowB && gateHighB))) shootErrs++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Records the first rise and fall edge index (1-based) of each gate.
  task automatic trace(input int n);
    logic [3:0] prev;
    prev = outs;
    for (int g = 0; g < 4; g++) begin
      riseAt[g] = -1;
      fallAt[g] = -1;
    end
    for (int e = 1; e <= n; e++) begin
      @(posedge clk);
      #1;
      for (int g = 0; g < 4; g++) begin
        if (riseAt[g] < 0 && outs[g] && !prev[g]) riseAt[g] = e;
        if (fallAt[g] < 0 && !outs[g] && prev[g]) fallAt[g] = e;
      end
      prev = outs;
    end
  endtask

  task automatic testReset();
    edges(3);
    chkEq("R13 gates low in reset", int'(outs), 0);
    rstN = 1'b1;
    edges(6);
    chkEq("R13 gates low while disabled after reset", int'(outs), 0);
  endtask

  task automatic testRefresh();
    cmdHighA = 1'b1;
    cmdLowB  = 1'b1;
    edges(4);
    chkEq("R2 commands ignored while disabled", int'(outs), 0);
    disableIn = 1'b0;
    trace(24);
    chkEq("R9 R13 lowA refresh start", riseAt[0], 3);
    chkEq("R9 lowA refresh end", fallAt[0], 3 + REFW);
    chkEq("R10 highA after refresh and dead time", riseAt[1], 3 + REFW + DEAD);
    chkEq("R9 lowB refresh start", riseAt[2], 3);
    chkEq("R12 lowB no gap after refresh", fallAt[2], -1);
    chkEq("R9 highB stays off", riseAt[3], -1);
  endtask

  task automatic testBootUv();
    uvBootA = 1'b1;
    #1;
    chkEq("R4 highA off at once", int'(gateHighA), 0);
    chkEq("R4 lowB untouched", int'(gateLowB), 1);
    edges(2);
    cmdLowA = 1'b1;
    trace(12);
    chkEq("R4 lowA follows command under boot flag", riseAt[0], DEAD + 2);
    uvBootA = 1'b0;
    cmdLowA = 1'b0;
    trace(12);
    chkEq("R4 lowA off", fallAt[0], 2);
    chkEq("R4 highA back after flag clears", riseAt[1], DEAD + 2);
  endtask

  task automatic testBistate();
    cmdLowA = 1'b1;
    trace(12);
    chkEq("R1 highA off after low command", fallAt[1], 2);
    chkEq("R8 lowA on after dead time", riseAt[0], DEAD + 2);
    cmdLowA = 1'b0;
    trace(12);
    chkEq("R8 lowA off promptly", fallAt[0], 2);
    chkEq("R8 highA on after dead time", riseAt[1], DEAD + 2);
  endtask

  task automatic testTiming();
    cmdLowB = 1'b0;
    trace(8);
    chkEq("R6 lowB turn-off", fallAt[2], 2);
    cmdLowB = 1'b1;
    trace(12);
    chkEq("R5 lowB turn-on", riseAt[2], DEAD + 2);
    cmdLowB = 1'b0;
    edges(4);
    deadCycles = '0;
    cmdLowB = 1'b1;
    trace(8);
    chkEq("R5 zero dead time acts as one", riseAt[2], 3);
    cmdLowB = 1'b0;
    edges(4);
    deadCycles = DT_W'(9);
    cmdLowB = 1'b1;
    trace(16);
    chkEq("R5 long dead time", riseAt[2], 11);
    cmdLowB = 1'b0;
    edges(4);
    deadCycles = DT_W'(DEAD);
  endtask

  task automatic testShortPulse();
    cmdLowB = 1'b1;
    edges(2);
    cmdLowB = 1'b0;
    trace(14);
    chkEq("R11 short pulse suppressed", riseAt[2], -1);
  endtask

  task automatic testMainUv();
    cmdLowB = 1'b1;
    edges(DEAD + 4);
    chkEq("R3 setup gates on", int'(outs), 4'b0110);
    uvMain = 1'b1;
    #1;
    chkEq("R3 all off at once", int'(outs), 0);
    edges(3);
    chkEq("R3 all off while flagged", int'(outs), 0);
    uvMain = 1'b0;
    trace(10);
    chkEq("R3 highA returns after dead time", riseAt[1], DEAD);
    chkEq("R3 lowB returns after dead time", riseAt[2], DEAD);
  endtask

  task automatic testDisable();
    disableIn = 1'b1;
    trace(6);
    chkEq("R2 highA cleared", fallAt[1], 2);
    chkEq("R2 lowB cleared", fallAt[2], 2);
    cmdLowA = 1'b1;
    edges(8);
    chkEq("R2 stays off with new command", int'(outs), 0);
    disableIn = 1'b0;
    trace(20);
    chkEq("R12 lowA rises at refresh", riseAt[0], 3);
    chkEq("R12 lowA no gap", fallAt[0], -1);
    chkEq("R1 highA held off by low command", riseAt[1], -1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    @(posedge clk);
    #1;
    testReset();
    testRefresh();
    testBootUv();
    testBistate();
    testTiming();
    testShortPulse();
    testMainUv();
    testDisable();
    chkEq("R7 leg overlap cycles", shootErrs, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule